// File: doc/BRIEF.md
# SPI Slave Register Command Port

This block is the slave side of a four-wire serial port that gives a host access to a small register file. The host pulls chip select low and sends an 8-bit command, most significant bit first. A write command is followed by a 24-bit word, which is committed once all of its bits have arrived. A read command makes the port shift the addressed register out on the data output, and the host may stop after one, two or three bytes. Address zero is a configuration register held inside the port. All other addresses go to an external register file through a simple write strobe and a combinational read address.

While a read is shifting out, every byte the host clocks in is decoded as a command. A read or write command takes effect at once and cuts the current read short. The reserved byte 0xFE is a no-op that lets the read run on, and unrecognised bytes are dropped. Serial inputs are synchronised into the system clock domain, which must run at least four times faster than the serial clock. The input line is sampled on serial-clock rising edges, and the output changes on falling edges.

States: IDLE (not selected), CMD (collecting a command byte), WDATA (collecting write data), RDATA (shifting out read data while collecting chained commands). Transitions: any state goes to IDLE when chip select rises. IDLE goes to CMD when selected. CMD goes to RDATA on a read command and to WDATA on a write command. WDATA goes to CMD after the 24th data bit. RDATA goes back to RDATA (restart) on a chained read, to WDATA on a chained write, and to CMD after 24 bits otherwise.

Top module: `spi_reg_cmd_port`

## Requirements
- R1: After reset, sdo_oe, reg_we and soft_rst are 0 and cfg_o is 0.
- R2: A command byte is taken MSB first. Bit 7 = 0 and bit 0 = 0 mark a register command, bit 6 = 1 selects write and 0 selects read, and bits 5:1 hold the address.
- R3: After the 24th data bit of a write (data MSB first), a non-zero address gives exactly one reg_we pulse carrying that address and word. Address 0 updates cfg_o instead and raises no reg_we.
- R4: On a read, sdo presents the register MSB first, changing on serial-clock falling edges. The first bit is valid before the first data rising edge. Address 0 returns cfg_o.
- R5: A read may be ended after 8 or 16 bits by raising chip select. Nothing is written, and the next transfer behaves normally.
- R6: A read or write command byte received during a read takes effect at that byte boundary. A chained read drives the new register from the next bit, and a chained write collects 24 bits and commits them.
- R7: During a read, the no-op byte 0xFE and unrecognised bytes leave the read running through all 24 bits.
- R8: In the command phase, a byte with bit 7 = 1 (other than 0xFE) or with bit 0 = 1 is ignored, and the next byte is decoded as a command.
- R9: With chip select high, sdo_oe is 0 and sclk/sdi have no effect. Raising chip select before a write's 24th bit leaves every register unchanged.
- R10: Writing address 0 with bit 0 = 1 gives a one-cycle soft_rst pulse and returns cfg_o to 0. Bit 0 then reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from host |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data to host |
| sdo_oe | output | 1 | Output enable for sdo pad |
| reg_raddr | output | 5 | Register file read address |
| reg_rdata | input | 24 | Register file read data (combinational) |
| reg_we | output | 1 | Register file write strobe |
| reg_waddr | output | 5 | Register file write address |
| reg_wdata | output | 24 | Register file write data |
| cfg_o | output | 24 | Configuration register contents |
| soft_rst | output | 1 | One-cycle soft reset pulse |

## Verification
The bench targets command chaining at the first and second byte boundaries of a read. A port that fails to decode during reads would keep streaming the old register, or would never commit the chained write. It interleaves no-op and malformed bytes into a read, where a decoder that treats them as commands would truncate the data. It aborts a write after 16 bits and toggles the serial clock while deselected; a careless counter would then commit a spurious write. It also sets the self-clearing reset bit, where a missing clear would leave the bit readable as 1.

// File: rtl/spi_rcp_pkg.sv
package spi_rcp_pkg;

    localparam int unsigned RCP_CMD_W  = 8;
    localparam int unsigned RCP_ADDR_W = 5;
    localparam int unsigned RCP_DATA_W = 24;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CMD,
        ST_WDATA,
        ST_RDATA
    } port_state_t;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_NOP,
        OP_READ,
        OP_WRITE
    } cmd_op_t;

endpackage

// File: rtl/spi_rcp_sync.sv
module spi_rcp_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic sdi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic sdi_s,
    output logic cs_act
);
    localparam int unsigned NSIG = 3;
    localparam logic [NSIG-1:0] IDLE_VAL = 3'b100;   // {cs_n, sdi, sclk}

    logic [NSIG-1:0] raw;
    logic [NSIG-1:0] pipe [STAGES];
    logic            sclk_d;

    assign raw = {cs_n, sdi, sclk};

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[s] <= IDLE_VAL;
                else        pipe[s] <= raw;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[s] <= IDLE_VAL;
                else        pipe[s] <= pipe[s-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= pipe[STAGES-1][0];
    end

    assign sclk_rise = pipe[STAGES-1][0] & ~sclk_d;
    assign sclk_fall = ~pipe[STAGES-1][0] & sclk_d;
    assign sdi_s     = pipe[STAGES-1][1];
    assign cs_act    = ~pipe[STAGES-1][2];

endmodule

// File: rtl/spi_rcp_decode.sv
module spi_rcp_decode
    import spi_rcp_pkg::*;
#(
    parameter int unsigned      CMD_W    = RCP_CMD_W,
    parameter int unsigned      ADDR_W   = RCP_ADDR_W,
    parameter logic [CMD_W-1:0] NOP_CODE = 8'hFE
) (
    input  logic [CMD_W-1:0]  cmd_byte,
    output cmd_op_t           op,
    output logic [ADDR_W-1:0] addr
);
    localparam int unsigned WR_BIT = CMD_W - 2;

    always_comb begin
        if (cmd_byte == NOP_CODE) begin
            op = OP_NOP;
        end else if (!cmd_byte[CMD_W-1] && !cmd_byte[0]) begin
            op = cmd_byte[WR_BIT] ? OP_WRITE : OP_READ;
        end else begin
            op = OP_NONE;
        end
    end

    assign addr = cmd_byte[ADDR_W:1];

endmodule

// File: rtl/spi_rcp_cfg.sv
module spi_rcp_cfg #(
    parameter int unsigned       DATA_W    = 24,
    parameter int unsigned       SRST_BIT  = 0,
    parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] cfg,
    output logic              soft_rst
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg      <= RESET_VAL;
            soft_rst <= 1'b0;
        end else begin
            soft_rst <= 1'b0;
            if (wr_en) begin
                if (wr_data[SRST_BIT]) begin
                    cfg      <= RESET_VAL;
                    soft_rst <= 1'b1;
                end else begin
                    cfg <= wr_data;
                end
            end
        end
    end

endmodule

// File: rtl/spi_reg_cmd_port.sv
module spi_reg_cmd_port
    import spi_rcp_pkg::*;
#(
    parameter int unsigned       CMD_W       = RCP_CMD_W,
    parameter int unsigned       ADDR_W      = RCP_ADDR_W,
    parameter int unsigned       DATA_W      = RCP_DATA_W,
    parameter int unsigned       SYNC_STAGES = 2,
    parameter logic [CMD_W-1:0]  NOP_CODE    = 8'hFE,
    parameter int unsigned       SRST_BIT    = 0,
    parameter logic [DATA_W-1:0] CFG_RESET   = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe,
    output logic [ADDR_W-1:0] reg_raddr,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              reg_we,
    output logic [ADDR_W-1:0] reg_waddr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] cfg_o,
    output logic              soft_rst
);
    localparam int unsigned      BIT_W     = $clog2(CMD_W);
    localparam int unsigned      CNT_W     = $clog2(DATA_W);
    localparam logic [BIT_W-1:0] BYTE_LAST = BIT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0] WORD_LAST = CNT_W'(DATA_W - 1);
    localparam logic [ADDR_W-1:0] CFG_ADDR = '0;

    // synchronised serial inputs
    logic sclk_rise, sclk_fall, sdi_s, cs_act;

    // state
    port_state_t state_q, state_d;

    // receive path
    logic [BIT_W-1:0]  bit_cnt_q;
    logic [CMD_W-2:0]  cmd_sr_q;
    logic [CMD_W-1:0]  rx_byte;
    logic [CNT_W-1:0]  data_cnt_q;
    logic [DATA_W-2:0] word_sr_q;
    logic [DATA_W-1:0] rx_word;

    // decode
    cmd_op_t           dec_op;
    logic [ADDR_W-1:0] dec_addr;
    logic              byte_done, word_done, act_read, act_write, commit;

    // transmit path and register side
    logic [ADDR_W-1:0] addr_q;
    logic              load_q;
    logic [DATA_W-1:0] tx_sr_q;
    logic              sdo_q, oe_q;
    logic              we_q;
    logic [ADDR_W-1:0] waddr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              cfg_wr;
    logic [DATA_W-1:0] cfg_q;

    spi_rcp_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .sdi       (sdi),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .sdi_s     (sdi_s),
        .cs_act    (cs_act)
    );

    assign rx_byte = {cmd_sr_q, sdi_s};
    assign rx_word = {word_sr_q, sdi_s};

    spi_rcp_decode #(
        .CMD_W    (CMD_W),
        .ADDR_W   (ADDR_W),
        .NOP_CODE (NOP_CODE)
    ) u_dec (
        .cmd_byte (rx_byte),
        .op       (dec_op),
        .addr     (dec_addr)
    );

    // a byte completes on the 8th rising edge while commands are being listened for
    assign byte_done = cs_act && sclk_rise && (bit_cnt_q == BYTE_LAST)
                       && ((state_q == ST_CMD) || (state_q == ST_RDATA));
    assign word_done = cs_act && sclk_rise && (data_cnt_q == WORD_LAST)
                       && ((state_q == ST_WDATA) || (state_q == ST_RDATA));
    assign act_read  = byte_done && (dec_op == OP_READ);
    assign act_write = byte_done && (dec_op == OP_WRITE);
    assign commit    = (state_q == ST_WDATA) && word_done;
    assign cfg_wr    = commit && (addr_q == CFG_ADDR);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!cs_act) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_CMD;
                ST_CMD: begin
                    if (act_read)       state_d = ST_RDATA;
                    else if (act_write) state_d = ST_WDATA;
                end
                ST_WDATA: begin
                    if (word_done) state_d = ST_CMD;
                end
                ST_RDATA: begin
                    if (act_read)       state_d = ST_RDATA;
                    else if (act_write) state_d = ST_WDATA;
                    else if (word_done) state_d = ST_CMD;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q  <= '0;
            cmd_sr_q   <= '0;
            data_cnt_q <= '0;
            word_sr_q  <= '0;
            addr_q     <= '0;
            load_q     <= 1'b0;
            tx_sr_q    <= '0;
            sdo_q      <= 1'b0;
            oe_q       <= 1'b0;
            we_q       <= 1'b0;
            waddr_q    <= '0;
            wdata_q    <= '0;
        end else begin
            we_q   <= 1'b0;
            load_q <= 1'b0;
            oe_q   <= cs_act;
            if (!cs_act) begin
                bit_cnt_q  <= '0;
                data_cnt_q <= '0;
                sdo_q      <= 1'b0;
            end else begin
                if (sclk_rise) begin
                    cmd_sr_q  <= rx_byte[CMD_W-2:0];
                    bit_cnt_q <= (bit_cnt_q == BYTE_LAST) ? '0 : bit_cnt_q + 1'b1;
                    if (state_q == ST_WDATA) begin
                        word_sr_q <= rx_word[DATA_W-2:0];
                    end
                    if ((state_q == ST_WDATA) || (state_q == ST_RDATA)) begin
                        data_cnt_q <= word_done ? '0 : data_cnt_q + 1'b1;
                    end
                end
                if (act_read || act_write) begin
                    addr_q     <= dec_addr;
                    data_cnt_q <= '0;
                    load_q     <= act_read;
                end
                if (commit && (addr_q != CFG_ADDR)) begin
                    we_q    <= 1'b1;
                    waddr_q <= addr_q;
                    wdata_q <= rx_word;
                end
                if (sclk_fall) begin
                    if (state_q == ST_RDATA) begin
                        sdo_q   <= tx_sr_q[DATA_W-1];
                        tx_sr_q <= {tx_sr_q[DATA_W-2:0], 1'b0};
                    end else begin
                        sdo_q <= 1'b0;
                    end
                end
                if (load_q) begin
                    tx_sr_q <= (addr_q == CFG_ADDR) ? cfg_q : reg_rdata;
                end
            end
        end
    end

    spi_rcp_cfg #(
        .DATA_W    (DATA_W),
        .SRST_BIT  (SRST_BIT),
        .RESET_VAL (CFG_RESET)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr),
        .wr_data  (rx_word),
        .cfg      (cfg_q),
        .soft_rst (soft_rst)
    );

    assign sdo       = sdo_q;
    assign sdo_oe    = oe_q;
    assign reg_raddr = addr_q;
    assign reg_we    = we_q;
    assign reg_waddr = waddr_q;
    assign reg_wdata = wdata_q;
    assign cfg_o     = cfg_q;

endmodule

// File: rtl/spi_rcp_checker.sv
module spi_rcp_checker #(
    parameter int unsigned       ADDR_W      = 5,
    parameter int unsigned       DATA_W      = 24,
    parameter int unsigned       SYNC_STAGES = 2,
    parameter logic [DATA_W-1:0] CFG_RESET   = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              cs_act,
    input logic              sdo_oe,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_waddr,
    input logic              soft_rst,
    input logic [DATA_W-1:0] cfg_o
);
    localparam int unsigned HI_LIM = SYNC_STAGES + 2;
    localparam int unsigned HI_W   = $clog2(HI_LIM + 1) + 1;

    logic [HI_W-1:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  hi_cnt <= '0;
        else if (!cs_n)              hi_cnt <= '0;
        else if (hi_cnt < HI_W'(HI_LIM)) hi_cnt <= hi_cnt + 1'b1;
    end

    AST_OE_OFF_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_cnt >= HI_W'(HI_LIM)) |-> !sdo_oe);                       // R9

    AST_WE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);                                          // R3

    AST_WE_NOT_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (reg_waddr != '0));                                // R3

    AST_WE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> $past(cs_act));                                    // R9

    AST_CFG_HELD_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> $stable(cfg_o));                                  // R9

    AST_SRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !soft_rst);                                      // R10

    AST_SRST_CFG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> (cfg_o == CFG_RESET));                           // R10

endmodule

bind spi_reg_cmd_port spi_rcp_checker #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .SYNC_STAGES (SYNC_STAGES),
    .CFG_RESET   (CFG_RESET)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .cs_act    (cs_act),
    .sdo_oe    (sdo_oe),
    .reg_we    (reg_we),
    .reg_waddr (reg_waddr),
    .soft_rst  (soft_rst),
    .cfg_o     (cfg_o)
);

// File: tb/tb_spi_reg_cmd_port.sv
`timescale 1ns/1ps
module tb_spi_reg_cmd_port;

    localparam int HALF = 8;            // system clocks per serial half period
    localparam logic [7:0] NOP = 8'hFE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic        sdo, sdo_oe, reg_we, soft_rst;
    logic [4:0]  reg_raddr, reg_waddr;
    logic [23:0] reg_rdata, reg_wdata, cfg_o;

    always #2 clk = ~clk;               // 250 MHz

    spi_reg_cmd_port dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
        .cfg_o(cfg_o), .soft_rst(soft_rst)
    );

    // external register file
    logic [23:0] rf [32];
    initial for (int i = 0; i < 32; i++) rf[i] = 24'h0;
    assign reg_rdata = rf[reg_raddr];
    always @(posedge clk) if (reg_we) rf[reg_waddr] <= reg_wdata;

    // reference model state
    typedef struct { logic [4:0] a; logic [23:0] d; } wr_t;
    wr_t         exp_q[$];
    logic [23:0] exp_rf [32];
    logic [23:0] exp_cfg = 24'h0;
    int          total = 0, bad = 0, srst_seen = 0, hi_cnt = 0, lo_cnt = 0;
    bit          finished = 0;

    initial for (int i = 0; i < 32; i++) exp_rf[i] = 24'h0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) if (rst_n) begin
        if (reg_we) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9 unexpected write", {3'b0, reg_waddr, reg_wdata}, 32'h0);
            end else begin
                wr_t e;
                e = exp_q.pop_front();
                chk({reg_waddr, reg_wdata} == {e.a, e.d}, "R3 write strobe",
                    {3'b0, reg_waddr, reg_wdata}, {3'b0, e.a, e.d});
            end
        end
        if (soft_rst) srst_seen++;
        hi_cnt = cs_n ? hi_cnt + 1 : 0;
        lo_cnt = cs_n ? 0 : lo_cnt + 1;
        if (hi_cnt > 4 && sdo_oe) chk(1'b0, "R9 oe while deselected", 1, 0);
        if (lo_cnt > 4 && !sdo_oe) chk(1'b0, "R9 oe missing while selected", 0, 1);
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_begin();
        @(negedge clk); sclk = 1'b0; cs_n = 1'b0; wait_clk(HALF);
    endtask

    task automatic cs_end();
        wait_clk(HALF / 2); sclk = 1'b0; wait_clk(HALF); cs_n = 1'b1; wait_clk(2 * HALF);
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk); sclk = 1'b0; sdi = tx[i];
            wait_clk(HALF);
            rx[i] = sdo;
            sclk = 1'b1;
            wait_clk(HALF - 1);
        end
    endtask

    function automatic logic [7:0] wcmd(input logic [4:0] a); return {2'b01, a, 1'b0}; endfunction
    function automatic logic [7:0] rcmd(input logic [4:0] a); return {2'b00, a, 1'b0}; endfunction

    function automatic logic [23:0] exp_read(input logic [4:0] a);
        return (a == 5'd0) ? exp_cfg : exp_rf[a];
    endfunction

    task automatic model_write(input logic [4:0] a, input logic [23:0] d);
        if (a == 5'd0) exp_cfg = d[0] ? 24'h0 : d;
        else begin
            wr_t e;
            e.a = a; e.d = d;
            exp_q.push_back(e);
            exp_rf[a] = d;
        end
    endtask

    task automatic send_word(input logic [23:0] d);
        logic [7:0] rx;
        xfer(d[23:16], rx); xfer(d[15:8], rx); xfer(d[7:0], rx);
    endtask

    task automatic write_reg(input logic [4:0] a, input logic [23:0] d);
        logic [7:0] rx;
        model_write(a, d);
        cs_begin(); xfer(wcmd(a), rx); send_word(d); cs_end();
    endtask

    task automatic read_chk(input logic [4:0] a, input int nbytes, input string req);
        logic [7:0]  rx;
        logic [23:0] e;
        e = exp_read(a);
        cs_begin(); xfer(rcmd(a), rx);
        for (int b = 0; b < nbytes; b++) begin
            xfer(NOP, rx);
            chk(rx == e[23-8*b -: 8], req, {24'h0, rx}, {24'h0, e[23-8*b -: 8]});
        end
        cs_end();
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL R1 watchdog expired actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rx;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);

        // R1 reset state
        chk(sdo_oe == 1'b0, "R1 sdo_oe", sdo_oe, 0);
        chk(reg_we == 1'b0, "R1 reg_we", reg_we, 0);
        chk(soft_rst == 1'b0, "R1 soft_rst", soft_rst, 0);
        chk(cfg_o == 24'h0, "R1 cfg_o", cfg_o, 0);

        // R2 R3 R4 writes and full reads
        write_reg(5'd5, 24'hA5C33C);
        write_reg(5'd1, 24'h123456);
        write_reg(5'd31, 24'hFFFF00);
        write_reg(5'd17, 24'h0F1E2D);
        read_chk(5'd5, 3, "R4 read addr5");
        read_chk(5'd31, 3, "R4 read addr31");
        read_chk(5'd17, 3, "R2 read addr17");

        // R3 R4 configuration register
        write_reg(5'd0, 24'h5A5A5A);
        chk(cfg_o == 24'h5A5A5A, "R3 cfg_o after write", cfg_o, 24'h5A5A5A);
        read_chk(5'd0, 3, "R4 read cfg");

        // R5 shortened reads, then a normal read
        read_chk(5'd1, 1, "R5 one-byte read");
        read_chk(5'd5, 2, "R5 two-byte read");
        read_chk(5'd1, 3, "R5 read after short reads");

        // R9 aborted write leaves register unchanged
        cs_begin(); xfer(wcmd(5'd9), rx); xfer(8'hDE, rx); xfer(8'hAD, rx); cs_end();
        read_chk(5'd9, 3, "R9 aborted write");

        // R9 sclk/sdi ignored while deselected
        begin
            logic [31:0] pat;
            pat = {wcmd(5'd3), 24'hBEEF01};
            for (int i = 31; i >= 0; i--) begin
                @(negedge clk); sclk = 1'b0; sdi = pat[i]; wait_clk(HALF);
                sclk = 1'b1; wait_clk(HALF - 1);
            end
            sclk = 1'b0; wait_clk(HALF);
            chk(sdo_oe == 1'b0, "R9 oe while toggling deselected", sdo_oe, 0);
        end
        read_chk(5'd3, 3, "R9 deselected traffic ignored");

        // R8 unknown command bytes in command phase
        begin
            logic [23:0] e;
            e = exp_rf[5];
            cs_begin(); xfer(8'h83, rx); xfer(8'h41, rx); xfer(rcmd(5'd5), rx);
            for (int b = 0; b < 3; b++) begin
                xfer(NOP, rx);
                chk(rx == e[23-8*b -: 8], "R8 read after unknown bytes", {24'h0, rx}, {24'h0, e[23-8*b -: 8]});
            end
            cs_end();
        end

        // R7 no-op and unknown bytes during a read
        begin
            logic [23:0] e;
            logic [7:0]  fill [3];
            e = exp_rf[31];
            fill[0] = NOP; fill[1] = 8'h95; fill[2] = 8'hC1;
            cs_begin(); xfer(rcmd(5'd31), rx);
            for (int b = 0; b < 3; b++) begin
                xfer(fill[b], rx);
                chk(rx == e[23-8*b -: 8], "R7 read undisturbed", {24'h0, rx}, {24'h0, e[23-8*b -: 8]});
            end
            cs_end();
        end

        // R6 chained read after the first byte
        begin
            logic [23:0] e5, e17;
            e5 = exp_rf[5]; e17 = exp_rf[17];
            cs_begin(); xfer(rcmd(5'd5), rx);
            xfer(NOP, rx);
            chk(rx == e5[23:16], "R6 first read byte", {24'h0, rx}, {24'h0, e5[23:16]});
            xfer(rcmd(5'd17), rx);
            chk(rx == e5[15:8], "R6 old read during chain", {24'h0, rx}, {24'h0, e5[15:8]});
            for (int b = 0; b < 3; b++) begin
                xfer(NOP, rx);
                chk(rx == e17[23-8*b -: 8], "R6 chained read data", {24'h0, rx}, {24'h0, e17[23-8*b -: 8]});
            end
            cs_end();
        end

        // R6 chained write during a read
        begin
            logic [23:0] e1;
            e1 = exp_rf[1];
            cs_begin(); xfer(rcmd(5'd1), rx);
            xfer(NOP, rx);
            chk(rx == e1[23:16], "R6 read before chained write", {24'h0, rx}, {24'h0, e1[23:16]});
            model_write(5'd2, 24'h6789AB);
            xfer(wcmd(5'd2), rx);
            send_word(24'h6789AB);
            cs_end();
        end
        read_chk(5'd2, 3, "R6 chained write committed");

        // R10 soft reset through the configuration register
        srst_seen = 0;
        write_reg(5'd0, 24'h3C0001);
        chk(srst_seen == 1, "R10 soft_rst pulses", srst_seen, 1);
        chk(cfg_o == 24'h0, "R10 cfg_o cleared", cfg_o, 0);
        read_chk(5'd0, 3, "R10 reset bit reads 0");

        chk(exp_q.size() == 0, "R3 all writes seen", exp_q.size(), 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule